// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the time base for a pulse-width modulator. A free-running divider turns the system clock into a slower tick. On each tick a 16-bit counter advances according to a selected count mode: upward, downward, up-down (triangle) or frozen. The counter is bounded by a programmable period. The block reports its current count, a tick enable for downstream compare and action logic, and one-cycle strobes when the count sits at zero or at the period.

Software programs two words through a simple write port. One is a control word that selects the count mode, the way the period is loaded, the two prescaler stages and the behaviour during a halt request. The other is the period. A period can be taken at once, or kept in a shadow copy that moves into the active period only when the counter reaches zero, so a waveform is never cut short in mid-cycle. A halt input, raised for example by a debugger, stops the counter in one of three ways: after one more count, at the end of the current cycle, or not at all.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the control word is 0 (count up, stop-after-one-more-count halt policy, immediate-load bit clear, prescale ratio 1) and the active and shadow periods are 0, so `tick` is high on every clock.
- R2: A write with `wr_sel`=0 loads the control word from `wr_data`: count mode in bits 1:0, immediate period load in bit 3, linear prescale field in bits 9:7, power-of-two prescale field in bits 12:10, halt policy in bits 15:14. A write with `wr_sel`=1 loads the period.
- R3: With power field p and linear field q, `tick` is high for one clock out of every 2^p × L clocks, where L is 1 for q=0 and 2·q otherwise.
- R4: In count-up mode (00) each advancing tick adds one to the count; a count at or above the active period goes to 0 instead.
- R5: In count-down mode (01) each advancing tick subtracts one; a count of 0 reloads the active period instead.
- R6: In up-down mode (10) the count moves by one per advancing tick and reverses direction on reaching the period and on reaching 0.
- R7: In frozen mode (11) the count does not change.
- R8: With bit 3 clear a period write goes only to the shadow copy, which becomes active on a tick with the count at 0; with bit 3 set the write takes effect on the next clock.
- R9: `zero_evt` and `prd_evt` are high for one clock, only together with `tick`, only while the counter is allowed to advance, and only when the count equals 0 or the active period respectively.
- R10: Halt policy 00: once `halt` rises the counter makes exactly one more step, then holds until `halt` falls.
- R11: Halt policy 01: under `halt` the counter keeps stepping until the count is 0, then holds at 0 until `halt` falls.
- R12: Halt policies 10 and 11: `halt` has no effect on counting.
- R13: The count changes only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the selected word |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data | input | CNT_W | Data written |
| halt | input | 1 | Halt request, applied through the halt policy |
| count | output | CNT_W | Current counter value |
| tick | output | 1 | One-clock enable per prescaled time-base clock |
| zero_evt | output | 1 | Strobe: counter at zero on an advancing tick |
| prd_evt | output | 1 | Strobe: counter at period on an advancing tick |

## Verification
The bound checker watches, on every clock, that the count moves only with a tick, that frozen mode holds it, that an upward step below the period is exactly plus one, that both strobes coincide with a tick and the matching count, that a free-run halt policy keeps stepping and that an end-of-cycle halt holds zero. The exact prescale spacing for chosen field values, the down and triangle sequences, the moment a shadowed period takes over as against an immediate one, and the one-extra-step stop after a halt are sequences over many cycles and are shown by the bench's directed scenarios.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

  // Width of the prescale ratio: 2^7 * 14 = 1792 fits in 11 bits.
  localparam int PS_W = 11;

  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_HOLD   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RC_ONE_MORE = 2'b00,
    RC_AT_ZERO  = 2'b01,
    RC_FREE_ALT = 2'b10,
    RC_FREE     = 2'b11
  } run_ctl_e;

  // Divide ratio = (linear factor) shifted left by the power field.
  function automatic logic [PS_W-1:0] prescale_ratio(input logic [2:0] pow,
                                                     input logic [2:0] lin);
    logic [PS_W-1:0] lin_f;
    lin_f = (lin == 3'd0) ? PS_W'(1) : PS_W'({lin, 1'b0});
    return lin_f << pow;
  endfunction

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale
  import pwm_timebase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pow,
  input  logic [2:0] lin,
  output logic       tick
);

  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] last_w;

  assign last_w = prescale_ratio(pow, lin) - PS_W'(1);
  // >= so that a ratio shrink while the divider is past the new end recovers
  assign tick   = (div_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + PS_W'(1);
  end

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_prd,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             imm_load,
  input  logic             zero_load,
  output logic [CNT_W-1:0] prd_active
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_prd) shadow_q <= wr_val;
      if (wr_prd && imm_load) active_q <= wr_val;
      else if (zero_load)     active_q <= shadow_q;
    end
  end

  assign prd_active = active_q;

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  cnt_mode_e        mode,
  input  run_ctl_e         run,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] count,
  output logic             step_en
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             down_q, down_n;
  logic             stepped_q;
  logic             run_ok;
  logic             at_zero, at_top;

  assign at_zero = (cnt_q == '0);
  assign at_top  = (cnt_q >= prd);

  // Halt policy decides whether this tick may advance the counter.
  always_comb begin
    unique case (run)
      RC_ONE_MORE: run_ok = !halt || !stepped_q;
      RC_AT_ZERO:  run_ok = !halt || !at_zero;
      default:     run_ok = 1'b1;
    endcase
  end

  assign step_en = tick && run_ok && (mode != CM_HOLD);

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    unique case (mode)
      CM_UP:   cnt_n = at_top ? '0 : cnt_q + CNT_W'(1);
      CM_DOWN: cnt_n = at_zero ? prd : cnt_q - CNT_W'(1);
      CM_UPDOWN: begin
        if (!down_q) begin
          if (at_top) begin
            down_n = 1'b1;
            cnt_n  = at_zero ? '0 : cnt_q - CNT_W'(1);
          end else begin
            cnt_n  = cnt_q + CNT_W'(1);
          end
        end else begin
          if (at_zero) begin
            down_n = 1'b0;
            cnt_n  = at_top ? '0 : CNT_W'(1);
          end else begin
            cnt_n  = cnt_q - CNT_W'(1);
          end
        end
      end
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      down_q    <= 1'b0;
      stepped_q <= 1'b0;
    end else begin
      if (step_en) begin
        cnt_q  <= cnt_n;
        down_q <= down_n;
      end
      if (!halt)        stepped_q <= 1'b0;
      else if (step_en) stepped_q <= 1'b1;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             halt,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             zero_evt,
  output logic             prd_evt
);

  // Control fields, kept as separate registers
  cnt_mode_e        mode_q;
  run_ctl_e         run_q;
  logic             imm_q;
  logic [2:0]       pow_q;
  logic [2:0]       lin_q;

  logic             wr_ctl, wr_prd;
  logic [CNT_W-1:0] prd_active;
  logic             step_en;
  logic             zero_load;
  logic             unused_ctl_bits;

  assign wr_ctl = wr_en && !wr_sel;
  assign wr_prd = wr_en &&  wr_sel;
  assign unused_ctl_bits = ^{wr_data[13], wr_data[6:4], wr_data[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CM_UP;
      run_q  <= RC_ONE_MORE;
      imm_q  <= 1'b0;
      pow_q  <= '0;
      lin_q  <= '0;
    end else if (wr_ctl) begin
      mode_q <= cnt_mode_e'(wr_data[1:0]);
      imm_q  <= wr_data[3];
      lin_q  <= wr_data[9:7];
      pow_q  <= wr_data[12:10];
      run_q  <= run_ctl_e'(wr_data[15:14]);
    end
  end

  pwm_tb_prescale u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .pow   (pow_q),
    .lin   (lin_q),
    .tick  (tick)
  );

  assign zero_load = tick && (count == '0);

  pwm_tb_period #(.CNT_W(CNT_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_prd     (wr_prd),
    .wr_val     (wr_data),
    .imm_load   (imm_q),
    .zero_load  (zero_load),
    .prd_active (prd_active)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .halt    (halt),
    .mode    (mode_q),
    .run     (run_q),
    .prd     (prd_active),
    .count   (count),
    .step_en (step_en)
  );

  assign zero_evt = step_en && (count == '0);
  assign prd_evt  = step_en && (count == prd_active);

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             zero_evt,
  input logic             prd_evt,
  input logic             step_en,
  input cnt_mode_e        mode,
  input run_ctl_e         run,
  input logic [CNT_W-1:0] prd_active
);

  // R13: counter only moves on a tick
  p_still_between_ticks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R7: frozen mode holds the count
  p_frozen_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD) |=> $stable(count));

  // R4: up step below the period adds exactly one
  p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mode == CM_UP && count < prd_active)
      |=> (count == $past(count) + CNT_W'(1)));

  // R9: zero strobe only on a tick at count zero
  p_zero_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (tick && count == '0));

  // R9: period strobe only on a tick at the period
  p_prd_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prd_evt |-> (tick && count == prd_active));

  // R12: free-run policies ignore halt
  p_free_ignores_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && halt && run[1] && mode == CM_UP && count < prd_active)
      |=> (count == $past(count) + CNT_W'(1)));

  // R11: end-of-cycle policy parks at zero under halt
  p_cycle_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && run == RC_AT_ZERO && count == '0) |=> (count == '0));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt       (halt),
  .tick       (tick),
  .count      (count),
  .zero_evt   (zero_evt),
  .prd_evt    (prd_evt),
  .step_en    (step_en),
  .mode       (mode_q),
  .run        (run_q),
  .prd_active (prd_active)
);

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         halt = 1'b0;
  logic [W-1:0] count;
  logic         tick, zero_evt, prd_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_timebase #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .halt(halt), .count(count), .tick(tick),
    .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling edge.
  task automatic wr_word(input bit sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int v, input string req);
    int k = 0;
    while (int'(count) != v && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk(int'(count) == v, req, int'(count), v);
  endtask

  task automatic expect_seq(input int seq[], input string req);
    foreach (seq[i]) begin
      @(negedge clk);
      chk(int'(count) == seq[i], req, int'(count), seq[i]);
    end
  endtask

  task automatic t_reset;
    chk(count == 0, "R1 count", int'(count), 0);
    chk(tick == 1'b1, "R1 tick every clock", int'(tick), 1);
    @(negedge clk);
    chk(count == 0 && tick, "R1 period zero holds count", int'(count), 0);
  endtask

  task automatic t_up;
    int prev;
    wr_word(1'b0, 16'hC008);   // R2: free, immediate load, up
    wr_word(1'b1, 16'd4);
    for (int i = 0; i < 12; i++) begin
      prev = int'(count);
      @(negedge clk);
      chk(int'(count) == ((prev >= 4) ? 0 : prev + 1), "R4 up step", int'(count),
          (prev >= 4) ? 0 : prev + 1);
      chk(zero_evt == (count == 0), "R9 zero strobe", int'(zero_evt), int'(count == 0));
      chk(prd_evt == (count == 4), "R9 period strobe", int'(prd_evt), int'(count == 4));
    end
  endtask

  task automatic t_down;
    int prev;
    wr_word(1'b0, 16'hC009);
    for (int i = 0; i < 12; i++) begin
      prev = int'(count);
      @(negedge clk);
      chk(int'(count) == ((prev == 0) ? 4 : prev - 1), "R5 down step", int'(count),
          (prev == 0) ? 4 : prev - 1);
    end
  endtask

  task automatic t_updown;
    int prev, delta, expv;
    bit seen_top = 0, seen_bot = 0;
    wr_word(1'b0, 16'hC00A);
    prev = int'(count);
    @(negedge clk);
    delta = int'(count) - prev;
    for (int i = 0; i < 20; i++) begin
      prev = int'(count);
      if (prev >= 4)      expv = prev - 1;
      else if (prev == 0) expv = 1;
      else                expv = prev + delta;
      @(negedge clk);
      chk(int'(count) == expv, "R6 up-down step", int'(count), expv);
      delta = int'(count) - prev;
      if (count == 4) seen_top = 1;
      if (count == 0) seen_bot = 1;
    end
    chk(seen_top && seen_bot, "R6 reaches both ends", int'(seen_top) + int'(seen_bot), 2);
  endtask

  task automatic t_freeze;
    int c;
    wr_word(1'b0, 16'hC00B);
    c = int'(count);
    repeat (6) @(negedge clk);
    chk(int'(count) == c, "R7 frozen", int'(count), c);
    chk(zero_evt == 0 && prd_evt == 0, "R9 no strobe when frozen",
        int'(zero_evt) + int'(prd_evt), 0);
  endtask

  task automatic measure_gap(input int exp_gap, input string req);
    int k = 0, gap = 0, c;
    while (!tick && k < 100) begin @(negedge clk); k++; end
    @(negedge clk);
    gap = 1;
    while (!tick && gap < 100) begin
      c = int'(count);
      chk(zero_evt == 0 && prd_evt == 0, "R9 strobe without tick",
          int'(zero_evt) + int'(prd_evt), 0);
      @(negedge clk);
      if (!tick) chk(int'(count) == c, "R13 count moved without tick", int'(count), c);
      gap++;
    end
    chk(gap == exp_gap, req, gap, exp_gap);
  endtask

  task automatic t_prescale;
    wr_word(1'b0, 16'hC500);   // pow=1, lin=2 -> 2*4 = 8
    measure_gap(8, "R3 ratio pow1 lin2");
    measure_gap(8, "R2 field positions repeat");
    wr_word(1'b0, 16'hC980);   // pow=2, lin=3 -> 4*6 = 24
    measure_gap(24, "R3 ratio pow2 lin3");
    wr_word(1'b0, 16'hCC00);   // pow=3, lin=0 -> 8
    measure_gap(8, "R3 ratio pow3 lin0");
    wr_word(1'b0, 16'hC000);
    measure_gap(1, "R3 ratio one");
  endtask

  task automatic t_shadow;
    // shadow mode, up, ratio 1; active period currently 4
    wait_count(1, "R8 setup");
    wr_word(1'b1, 16'd2);
    chk(count == 2, "R8 shadow write", int'(count), 2);
    expect_seq('{3, 4, 0, 1, 2, 0, 1}, "R8 shadow loads at zero");
  endtask

  task automatic t_immediate;
    wr_word(1'b0, 16'hC008);
    wait_count(1, "R8 setup");
    wr_word(1'b1, 16'd5);
    chk(count == 2, "R8 immediate write", int'(count), 2);
    expect_seq('{3, 4, 5, 0, 1}, "R8 immediate period");
  endtask

  task automatic t_halt_step;
    wr_word(1'b0, 16'h0008);
    wait_count(1, "R10 setup");
    halt = 1'b1;
    expect_seq('{2, 2, 2, 2, 2}, "R10 one more step then hold");
    halt = 1'b0;
    expect_seq('{3, 4}, "R10 resume");
  endtask

  task automatic t_halt_cycle;
    wr_word(1'b0, 16'h4008);
    wait_count(2, "R11 setup");
    halt = 1'b1;
    expect_seq('{3, 4, 5, 0, 0, 0, 0}, "R11 park at zero");
    chk(zero_evt == 0, "R9 no zero strobe while parked", int'(zero_evt), 0);
    halt = 1'b0;
    expect_seq('{1, 2}, "R11 resume");
  endtask

  task automatic t_halt_free;
    wr_word(1'b0, 16'hC008);
    halt = 1'b1;
    wait_count(1, "R12 setup");
    expect_seq('{2, 3, 4, 5, 0, 1}, "R12 policy 11 ignores halt");
    wr_word(1'b0, 16'h8008);
    wait_count(4, "R12 setup alt");
    expect_seq('{5, 0, 1, 2}, "R12 policy 10 ignores halt");
    halt = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_updown();
    t_freeze();
    t_prescale();
    t_shadow();
    t_immediate();
    t_halt_step();
    t_halt_cycle();
    t_halt_free();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (scenarios completed)");
      summary();
      $finish;
    end
  end

endmodule